// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single line that rests high. Software places a word into a holding register. When the shift stage is free and sending is enabled, the word moves into the shift stage on the next bit tick. The frame then goes out as a low start bit, 7, 8 or 9 data bits with the least significant bit first, an optional parity bit and a high stop bit. The line changes only on the bit tick, which is a one-cycle pulse from an external baud generator.

A mode input selects single or double buffering. In single-buffer mode, a new word is accepted only while nothing is being sent. The transmit interrupt fires as the stop bit begins, so software can write the next word. In double-buffer mode, the holding register can be refilled while a frame is still shifting. The interrupt fires at the moment a word moves into the shift stage. A queued word follows the previous stop bit with no idle bit between them. The format and the mode are captured when a frame starts, and later changes affect only later frames.

Top module: `uart_dbtx`

## Requirements
- R1: After reset, and whenever the block holds no word and sends no frame, `txd` is 1, `busy` is 0 and `tx_irq` is 0.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, then an optional parity bit, then a 1 stop bit. Each bit occupies one tick period, and `txd` changes only on a clock edge where `tick` was 1.
- R3: The `fmt` field selects the frame format. 0 gives 7 data bits (`wr_data[6:0]`). 1 gives 7 data bits plus parity. 2 gives 8 data bits. 3 gives 8 data bits plus parity. 4 gives 9 data bits. The values 5 to 7 behave as 2.
- R4: The parity bit is the XOR of the sent data bits when `par_odd` is 0, which gives even parity. When `par_odd` is 1, it is the inverse of that XOR, which gives odd parity.
- R5: A write is accepted only when the holding register is empty. In single-buffer mode (`dbl_buf` = 0), the shift stage must also be idle. A write that is not accepted is dropped and never sent.
- R6: In a frame started with `dbl_buf` = 0, `tx_irq` pulses for one cycle at the edge where the stop bit begins.
- R7: In a frame started with `dbl_buf` = 1, `tx_irq` pulses for one cycle at the edge where the word moves into the shift stage, which is the edge where the start bit begins. There is no pulse at the stop bit.
- R8: If a word is waiting and `tx_en` is 1 when the stop bit ends, the next start bit begins on that same tick, with no idle bit.
- R9: No frame starts while `tx_en` is 0, and a waiting word stays held. Clearing `tx_en` during a frame lets that frame complete.
- R10: The values of `fmt`, `par_odd` and `dbl_buf` at frame start govern the whole frame, including when its interrupt fires.
- R11: `busy` is 1 exactly while a frame is in progress (from its start bit through its stop bit) or a word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle bit-time pulse |
| tx_en | input | 1 | Allows new frames to start |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DW (9) | Word to send |
| fmt | input | 3 | Frame format select |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| dbl_buf | input | 1 | 1 selects double buffering |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress or a word is held |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The assertions check, on every cycle, that the line moves only after a tick and rests high whenever the block is empty. They also check that each interrupt pulse follows a tick and falls on a start bit or a stop bit according to the captured mode, and that `busy` is high during the pulse. Only the bench scenarios can show the rest, by comparing every cycle against a queue-based model of the frame bits. This covers the actual bit order and parity values of each format, and the dropping of refused writes in both modes. It also covers the gapless chaining of queued words, holding a word while sending is disabled, and frames ignoring control changes made in mid-flight.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // number of data bits for a format code
  function automatic logic [3:0] fmt_nbits(input logic [2:0] f);
    case (f)
      3'd0, 3'd1: fmt_nbits = 4'd7;
      3'd4:       fmt_nbits = 4'd9;
      default:    fmt_nbits = 4'd8;
    endcase
  endfunction

  // format carries a parity bit
  function automatic logic fmt_has_par(input logic [2:0] f);
    fmt_has_par = (f == 3'd1) || (f == 3'd3);
  endfunction

endpackage

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          dbl_buf,
  input  logic          sh_idle,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q, full_d;
  logic [DW-1:0] data_q;
  logic          accept;

  // R5: single mode needs an idle shifter, both modes need an empty holder
  assign accept = wr_stb && !full_q && (dbl_buf || sh_idle);

  always_comb begin
    full_d = full_q;
    if (take)   full_d = 1'b0;
    if (accept) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/uart_dbtx_par.sv
module uart_dbtx_par #(
  parameter int DW = 9,
  parameter int CW = 4
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] nbits,
  input  logic          odd,
  output logic          par
);

  logic [DW-1:0] used;

  // R4: only the bits that the format sends take part
  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign used[i] = data[i] && (CW'(i) < nbits);
  end

  assign par = (^used) ^ odd;

endmodule

// File: rtl/uart_dbtx_shift.sv
module uart_dbtx_shift
  import uart_dbtx_pkg::*;
#(
  parameter int DW = 9,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic [CW-1:0] ld_nbits,
  input  logic          ld_paren,
  input  logic          ld_parbit,
  input  logic          dbl_buf,
  output logic          take,
  output logic          idle,
  output logic          txd,
  output logic          irq,
  output logic          frame_dbl
);

  tx_state_e     st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d, nb_q, nb_d;
  logic          pen_q, pen_d, pbit_q, pbit_d, dbl_q, dbl_d;
  logic          txd_q, txd_d, irq_d;
  logic          can_load;

  assign can_load = hold_full && tx_en;                          // R9
  assign take     = tick && can_load && (st_q == ST_IDLE || st_q == ST_STOP);

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    nb_d   = nb_q;
    pen_d  = pen_q;
    pbit_d = pbit_q;
    dbl_d  = dbl_q;
    txd_d  = txd_q;
    irq_d  = 1'b0;
    if (tick) begin
      case (st_q)
        ST_IDLE, ST_STOP: begin
          if (can_load) begin                                    // R8, R10
            st_d   = ST_START;
            txd_d  = 1'b0;
            sh_d   = hold_data;
            nb_d   = ld_nbits;
            pen_d  = ld_paren;
            pbit_d = ld_parbit;
            dbl_d  = dbl_buf;
            irq_d  = dbl_buf;                                    // R7
            cnt_d  = '0;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_START: begin
          st_d  = ST_DATA;
          txd_d = sh_q[0];
          sh_d  = sh_q >> 1;
          cnt_d = CW'(1);
        end
        ST_DATA: begin
          if (cnt_q == nb_q) begin
            if (pen_q) begin
              st_d  = ST_PAR;
              txd_d = pbit_q;
            end else begin
              st_d  = ST_STOP;
              txd_d = 1'b1;
              irq_d = !dbl_q;                                    // R6
            end
          end else begin
            txd_d = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          st_d  = ST_STOP;
          txd_d = 1'b1;
          irq_d = !dbl_q;                                        // R6
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      nb_q   <= '0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      dbl_q  <= 1'b0;
      txd_q  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      nb_q   <= nb_d;
      pen_q  <= pen_d;
      pbit_q <= pbit_d;
      dbl_q  <= dbl_d;
      txd_q  <= txd_d;
      irq    <= irq_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign txd       = txd_q;
  assign frame_dbl = dbl_q;

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
  import uart_dbtx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    fmt,
  input  logic          par_odd,
  input  logic          dbl_buf,
  output logic          txd,
  output logic          busy,
  output logic          tx_irq
);

  localparam int CW = $clog2(DW + 1);

  logic [1:0]    rsync_q;
  logic          rst_n_s;
  logic          hold_full, sh_idle, take, frame_dbl, parbit;
  logic [DW-1:0] hold_data;
  logic [CW-1:0] ld_nbits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign ld_nbits = CW'(fmt_nbits(fmt));                         // R3

  uart_dbtx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .wr_stb(wr_stb), .wr_data(wr_data),
    .dbl_buf(dbl_buf), .sh_idle(sh_idle), .take(take),
    .full(hold_full), .data(hold_data)
  );

  uart_dbtx_par #(.DW(DW), .CW(CW)) u_par (
    .data(hold_data), .nbits(ld_nbits), .odd(par_odd), .par(parbit)
  );

  uart_dbtx_shift #(.DW(DW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .tx_en(tx_en),
    .hold_full(hold_full), .hold_data(hold_data), .ld_nbits(ld_nbits),
    .ld_paren(fmt_has_par(fmt)), .ld_parbit(parbit), .dbl_buf(dbl_buf),
    .take(take), .idle(sh_idle), .txd(txd), .irq(tx_irq),
    .frame_dbl(frame_dbl)
  );

  assign busy = hold_full || !sh_idle;                           // R11

endmodule

// File: rtl/uart_dbtx_chk.sv
module uart_dbtx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic txd,
  input logic busy,
  input logic tx_irq,
  input logic frame_dbl
);

  a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  a_r1_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r6_irq_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !frame_dbl) |-> txd);

  a_r7_irq_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && frame_dbl) |-> !txd);

  a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(tick));

  a_r11_irq_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> busy);

endmodule

bind uart_dbtx uart_dbtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .busy(busy),
  .tx_irq(tx_irq), .frame_dbl(frame_dbl)
);

// File: tb/uart_dbtx_bench.sv
module uart_dbtx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_en = 1'b1;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] fmt = 3'd2;
  logic       par_odd = 1'b0;
  logic       dbl_buf = 1'b0;
  logic       txd, busy, tx_irq;

  int n_chk = 0, n_fail = 0, cyc = 0, div = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  // behavioural reference
  bit q[$];
  bit m_active, m_full, m_line, m_irq, m_fdbl;
  logic [8:0] m_word;

  always #4 clk = ~clk;

  uart_dbtx u_uart_dbtx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .fmt(fmt), .par_odd(par_odd), .dbl_buf(dbl_buf),
    .txd(txd), .busy(busy), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bit tick every 4 cycles
  always @(negedge clk) begin
    tick <= (div == 3);
    div  <= (div + 1) % 4;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_active = 0; m_full = 0; m_line = 1; m_irq = 0; m_fdbl = 0; m_word = '0;
    end else begin
      bit acc;
      acc = wr_stb && !m_full && (dbl_buf || !m_active);   // R5
      m_irq = 0;
      if (tick) begin
        if (m_active && q.size() > 0) begin
          m_line = q.pop_front();
          if (q.size() == 0 && !m_fdbl) m_irq = 1;          // R6
        end else begin
          m_active = 0;
          if (m_full && tx_en) begin                        // R8, R9
            int n;
            bit p;
            n = (fmt == 3'd0 || fmt == 3'd1) ? 7 : (fmt == 3'd4) ? 9 : 8;
            p = 0;
            for (int i = 0; i < n; i++) begin
              q.push_back(m_word[i]);
              p ^= m_word[i];
            end
            if (fmt == 3'd1 || fmt == 3'd3) q.push_back(p ^ par_odd);
            q.push_back(1'b1);
            m_line = 0; m_active = 1; m_fdbl = dbl_buf; m_irq = dbl_buf; // R7
            m_full = 0;
          end
        end
      end
      if (acc) begin m_full = 1; m_word = wr_data; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk(txd == m_line, {tag, " txd"}, txd, m_line);
      chk(tx_irq == m_irq, {tag, " irq"}, tx_irq, m_irq);
      chk(busy == (m_active || m_full), {tag, " busy R11"}, busy, m_active || m_full);
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [8:0] d);
    @(negedge clk); wr_stb = 1; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic wait_done();
    while (m_active || m_full) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(txd == 1 && busy == 0 && tx_irq == 0, "R1 reset", {txd, busy, tx_irq}, 3'b100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    chk(txd == 1 && busy == 0, "R1 after release", {txd, busy}, 2'b10);

    // R2, R3, R6: single mode, each format, both parity senses (R4)
    tag = "R2 R3 R4 R6";
    for (int f = 0; f < 6; f++) begin
      fmt = 3'(f); par_odd = f[0];
      wr(9'h1A5 ^ 9'(f * 37));
      wait_done();
      par_odd = ~par_odd;
      wr(9'h0F3 + 9'(f));
      wait_done();
    end

    // R5: refused write in single mode while busy
    tag = "R5 single";
    fmt = 3'd2;
    wr(9'h055);
    repeat (10) @(negedge clk);
    wr(9'h0AA);
    wait_done();
    chk(txd == 1 && busy == 0, "R5 refused word not sent", busy, 0);

    // R7, R8, R5: double mode chaining and refusal while holder full
    tag = "R7 R8 R5 double";
    dbl_buf = 1; fmt = 3'd3;
    wr(9'h0C3);
    while (m_full) @(negedge clk);
    wr(9'h13C);
    wr(9'h1FF);
    wait_done();

    // R9: no start while disabled, word held; mid-frame disable completes
    tag = "R9";
    tx_en = 0;
    wr(9'h066);
    repeat (20) @(negedge clk);
    chk(busy == 1 && txd == 1, "R9 held while disabled", {busy, txd}, 2'b11);
    tx_en = 1;
    while (m_full) @(negedge clk);
    wr(9'h099);
    repeat (6) @(negedge clk);
    tx_en = 0;
    repeat (60) @(negedge clk);
    chk(busy == 1 && txd == 1, "R9 queued word held", {busy, txd}, 2'b11);
    tx_en = 1;
    wait_done();

    // R10: control changes mid-frame do not affect the frame
    tag = "R10";
    dbl_buf = 0; fmt = 3'd3; par_odd = 0;
    wr(9'h0B7);
    repeat (14) @(negedge clk);
    fmt = 3'd4; par_odd = 1; dbl_buf = 1;
    wait_done();
    dbl_buf = 1; fmt = 3'd0;
    wr(9'h07E);
    repeat (10) @(negedge clk);
    dbl_buf = 0; fmt = 3'd4;
    wait_done();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule